// File: doc/BRIEF.md
# Bus Width Adapter With Lane Steering

This block connects a 32-bit internal requester to an external data bus whose region may be wired as a 32-bit, 16-bit or 8-bit port. A request of one byte, one halfword, one word or a whole line of `LINE_WORDS` words is cut into port-sized beats. Each beat's bytes are placed on the byte lanes the port occupies, with matching byte enables. The beats are handed one at a time to an external timing sequencer through a valid/acknowledge pair. On reads the returned lanes are gathered back, and the block presents the assembled result once the final beat has been acknowledged.

Four configuration inputs shape each transfer. The port can sit on the upper or the lower lanes of the bus. Burst signalling is enabled separately for reads and for writes. Byte enables can be kept for writes only or driven on reads as well. The configuration is captured when a request is accepted, so the beats of one transfer all follow a single setting.

Top module: `bus_width_adapter`

## Requirements
- R1: After reset `req_ready` is 1, while `bus_valid`, `rsp_done` and `rsp_rdata` are all 0.
- R2: `req_size` 0/1/2/3 means 1, 2, 4 or 4*LINE_WORDS bytes. The beat size is the smaller of that count and the port width, and the transfer has count/beat beats. Beat i is issued at `req_addr + i*beat`, and it ends on a clock edge where `bus_valid` and `bus_ack` are both 1.
- R3: `cfg_port` 2'b01 is an 8-bit port, 2'b10 is a 16-bit port, and 2'b00 or 2'b11 is a 32-bit port. Lane n is bits 8n+7:8n. With `cfg_low_lanes`=0, the byte at offset o inside the port (offset = address modulo port width) sits on lane 3-o.
- R4: With `cfg_low_lanes`=1, a narrow port of P bytes puts offset o on lane P-1-o. A 32-bit port is unaffected.
- R5: Data are ordered big-endian and the most significant byte goes out first. A line word k (address `req_addr`+4k) is `req_wdata[32k+31:32k]`. A byte or halfword is right-justified in `req_wdata[15:0]`.
- R6: `bus_burst` is 1 on every beat except the last when the matching enable (`cfg_burst_wr` for writes, `cfg_burst_rd` for reads) is 1 and the transfer has more than one beat. Otherwise it stays 0.
- R7: Writes assert `bus_be` on exactly the lanes carrying the beat's bytes. Reads do the same only when `cfg_be_reads`=1 and give 4'b0000 otherwise. `bus_wdata` is zero on unused lanes and on reads.
- R8: `rsp_rdata` is 0 from each request acceptance until a read completes, and then holds the gathered result, zero-extended, until the next acceptance. A byte or halfword is right-justified and line words are laid out as in R5. Lanes outside the beat are ignored.
- R9: `rsp_done` is a single-cycle pulse in the cycle after the last beat's acknowledge. `req_ready` is 0 from the cycle after acceptance until that same cycle.
- R10: Configuration changes after a request has been accepted do not affect that transfer.
- R11: While `bus_valid` is 1 and `bus_ack` is 0, the beat (`bus_valid`, address, lanes, enables, burst) is held unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_port | input | 2 | Port width code |
| cfg_low_lanes | input | 1 | Narrow port occupies the low lanes |
| cfg_burst_wr | input | 1 | Burst signalling for writes |
| cfg_burst_rd | input | 1 | Burst signalling for reads |
| cfg_be_reads | input | 1 | Drive byte enables on reads too |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code |
| req_addr | input | AW | Start byte address, naturally aligned |
| req_wdata | input | 32*LINE_WORDS | Write data |
| rsp_done | output | 1 | Transfer complete pulse |
| rsp_rdata | output | 32*LINE_WORDS | Gathered read result |
| bus_valid | output | 1 | Beat request to the sequencer |
| bus_ack | input | 1 | Beat acknowledge from the sequencer |
| bus_addr | output | AW | Beat byte address |
| bus_write | output | 1 | Beat direction |
| bus_burst | output | 1 | More beats follow in this burst |
| bus_be | output | 4 | Byte-lane enables |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rdata | input | 32 | Read data lanes |

## Verification
The end of one transfer and the acceptance of the next can fall in the same cycle: `rsp_done` is high, `req_ready` has just returned, and a waiting request is taken. The bench provokes this by issuing each new request in the first cycle `req_ready` is seen high, including a read followed by a write and then another read. The reference model judges that the finished read's result is visible for exactly that cycle. It then checks that `rsp_rdata` returns to zero and that the new transfer's first beat appears in the next cycle with the new address and lanes.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

    typedef enum logic [1:0] {
        PORT_W32  = 2'b00,
        PORT_W8   = 2'b01,
        PORT_W16  = 2'b10,
        PORT_W32X = 2'b11
    } port_code_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LINE = 2'd3
    } size_code_e;

    // Width in bytes of the external port for a given code.
    function automatic logic [2:0] port_bytes(input logic [1:0] code);
        case (port_code_e'(code))
            PORT_W8:  return 3'd1;
            PORT_W16: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/bwa_stream_pack.sv
// Converts request write data into a big-endian byte stream (stream[0] first).
module bwa_stream_pack #(
    parameter int NBYTES = 16,
    parameter int CW     = 5
) (
    input  logic [CW-1:0]           total,
    input  logic [8*NBYTES-1:0]     flat,
    output logic [NBYTES-1:0][7:0]  stream
);

    always_comb begin
        stream = '0;
        if (total >= CW'(4)) begin
            for (int k = 0; k < NBYTES; k++) begin
                if (CW'(k) < total) begin
                    stream[k] = flat[32*(k/4) + 8*(3 - (k % 4)) +: 8];
                end
            end
        end else if (total == CW'(2)) begin
            stream[0] = flat[15:8];
            stream[1] = flat[7:0];
        end else begin
            stream[0] = flat[7:0];
        end
    end

endmodule

// File: rtl/bwa_stream_unpack.sv
// Rebuilds the requester-side data word(s) from a gathered byte stream.
module bwa_stream_unpack #(
    parameter int NBYTES = 16,
    parameter int CW     = 5
) (
    input  logic [CW-1:0]           total,
    input  logic [NBYTES-1:0][7:0]  stream,
    output logic [8*NBYTES-1:0]     flat
);

    always_comb begin
        flat = '0;
        if (total >= CW'(4)) begin
            for (int k = 0; k < NBYTES; k++) begin
                if (CW'(k) < total) begin
                    flat[32*(k/4) + 8*(3 - (k % 4)) +: 8] = stream[k];
                end
            end
        end else if (total == CW'(2)) begin
            flat[15:8] = stream[0];
            flat[7:0]  = stream[1];
        end else begin
            flat[7:0] = stream[0];
        end
    end

endmodule

// File: rtl/bwa_lane_steer.sv
// Maps beat byte j to a bus lane and back, for write steering and read gathering.
module bwa_lane_steer (
    input  logic [2:0]      port_bytes,
    input  logic            low_lanes,
    input  logic [1:0]      start_off,
    input  logic [2:0]      beat_bytes,
    input  logic [3:0][7:0] beat_data,
    input  logic [31:0]     bus_rdata,
    output logic [31:0]     lane_data,
    output logic [3:0]      lane_mask,
    output logic [3:0][7:0] gathered
);

    logic [3:0][7:0] lanes_in;
    int              top_lane;
    int              ln;

    assign lanes_in = bus_rdata;

    always_comb begin
        lane_data = '0;
        lane_mask = '0;
        gathered  = '0;
        top_lane  = low_lanes ? (int'(port_bytes) - 1) : 3;
        ln        = 0;
        for (int j = 0; j < 4; j++) begin
            ln = top_lane - int'(start_off) - j;
            if ((j < int'(beat_bytes)) && (ln >= 0) && (ln < 4)) begin
                lane_mask[ln]          = 1'b1;
                lane_data[8*ln +: 8]   = beat_data[j];
                gathered[j]            = lanes_in[ln];
            end
        end
    end

endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter #(
    parameter int LINE_WORDS = 4,
    parameter int AW         = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             cfg_port,
    input  logic                   cfg_low_lanes,
    input  logic                   cfg_burst_wr,
    input  logic                   cfg_burst_rd,
    input  logic                   cfg_be_reads,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [1:0]             req_size,
    input  logic [AW-1:0]          req_addr,
    input  logic [32*LINE_WORDS-1:0] req_wdata,
    output logic                   rsp_done,
    output logic [32*LINE_WORDS-1:0] rsp_rdata,
    output logic                   bus_valid,
    input  logic                   bus_ack,
    output logic [AW-1:0]          bus_addr,
    output logic                   bus_write,
    output logic                   bus_burst,
    output logic [3:0]             bus_be,
    output logic [31:0]            bus_wdata,
    input  logic [31:0]            bus_rdata
);
    import bwa_pkg::*;

    localparam int DW   = 32 * LINE_WORDS;
    localparam int MAXB = 4 * LINE_WORDS;
    localparam int OW   = $clog2(MAXB + 1);
    localparam int IW   = $clog2(MAXB);

    typedef struct packed {
        logic                  busy;
        logic                  wr;
        logic [2:0]            pb;
        logic                  low;
        logic                  bst;
        logic                  be_rd;
        logic [AW-1:0]         addr;
        logic [OW-1:0]         total;
        logic [2:0]            beat;
        logic [OW-1:0]         off;
        logic [MAXB-1:0][7:0]  bytes;
        logic                  done;
        logic                  rd_avail;
    } state_t;

    state_t s_q, s_d;

    // Request decode
    logic [OW-1:0]          req_total;
    logic [2:0]             req_pb;
    logic [MAXB-1:0][7:0]   req_stream;

    // Current beat
    logic [AW-1:0]          cur_addr;
    logic [1:0]             start_off;
    logic                   last_beat;
    logic [3:0][7:0]        beat_data;
    logic [31:0]            lane_data;
    logic [3:0]             lane_mask;
    logic [3:0][7:0]        gathered;
    logic [DW-1:0]          unpacked;
    logic [OW:0]            rd_idx;
    logic [OW:0]            wr_idx;

    always_comb begin
        case (size_code_e'(req_size))
            SZ_BYTE: req_total = OW'(1);
            SZ_HALF: req_total = OW'(2);
            SZ_WORD: req_total = OW'(4);
            default: req_total = OW'(MAXB);
        endcase
    end

    assign req_pb = port_bytes(cfg_port);

    bwa_stream_pack #(.NBYTES(MAXB), .CW(OW)) u_pack (
        .total  (req_total),
        .flat   (req_wdata),
        .stream (req_stream)
    );

    assign cur_addr  = s_q.addr + AW'(s_q.off);
    assign start_off = cur_addr[1:0] & (s_q.pb[1:0] - 2'd1);
    assign last_beat = ({1'b0, s_q.off} + (OW+1)'(s_q.beat)) >= {1'b0, s_q.total};

    always_comb begin
        rd_idx = '0;
        for (int j = 0; j < 4; j++) begin
            rd_idx       = {1'b0, s_q.off} + (OW+1)'(j);
            beat_data[j] = (rd_idx < (OW+1)'(MAXB)) ? s_q.bytes[rd_idx[IW-1:0]] : 8'h00;
        end
    end

    bwa_lane_steer u_steer (
        .port_bytes (s_q.pb),
        .low_lanes  (s_q.low),
        .start_off  (start_off),
        .beat_bytes (s_q.beat),
        .beat_data  (beat_data),
        .bus_rdata  (bus_rdata),
        .lane_data  (lane_data),
        .lane_mask  (lane_mask),
        .gathered   (gathered)
    );

    bwa_stream_unpack #(.NBYTES(MAXB), .CW(OW)) u_unpack (
        .total  (s_q.total),
        .stream (s_q.bytes),
        .flat   (unpacked)
    );

    // Next-state computation
    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        wr_idx   = '0;
        if (!s_q.busy) begin
            if (req_valid) begin
                s_d.busy     = 1'b1;
                s_d.wr       = req_write;
                s_d.pb       = req_pb;
                s_d.low      = cfg_low_lanes;
                s_d.bst      = req_write ? cfg_burst_wr : cfg_burst_rd;
                s_d.be_rd    = cfg_be_reads;
                s_d.addr     = req_addr;
                s_d.total    = req_total;
                s_d.beat     = (req_total < OW'(req_pb)) ? req_total[2:0] : req_pb;
                s_d.off      = '0;
                s_d.bytes    = req_write ? req_stream : '0;
                s_d.rd_avail = 1'b0;
            end
        end else if (bus_ack) begin
            if (!s_q.wr) begin
                for (int j = 0; j < 4; j++) begin
                    wr_idx = {1'b0, s_q.off} + (OW+1)'(j);
                    if ((3'(j) < s_q.beat) && (wr_idx < (OW+1)'(MAXB))) begin
                        s_d.bytes[wr_idx[IW-1:0]] = gathered[j];
                    end
                end
            end
            s_d.off = s_q.off + OW'(s_q.beat);
            if (last_beat) begin
                s_d.busy     = 1'b0;
                s_d.done     = 1'b1;
                s_d.rd_avail = !s_q.wr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = !s_q.busy;
    assign bus_valid = s_q.busy;
    assign bus_addr  = cur_addr;
    assign bus_write = s_q.busy & s_q.wr;
    assign bus_burst = s_q.busy & s_q.bst & !last_beat;
    assign bus_be    = (s_q.busy && (s_q.wr || s_q.be_rd)) ? lane_mask : 4'b0000;
    assign bus_wdata = (s_q.busy && s_q.wr) ? lane_data : 32'h0;
    assign rsp_done  = s_q.done;
    assign rsp_rdata = s_q.rd_avail ? unpacked : '0;

endmodule

// File: rtl/bwa_checker.sv
module bwa_checker #(
    parameter int AW = 32,
    parameter int DW = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          bus_valid,
    input logic          bus_ack,
    input logic [AW-1:0] bus_addr,
    input logic          bus_write,
    input logic          bus_burst,
    input logic [3:0]    bus_be,
    input logic [31:0]   bus_wdata,
    input logic          rsp_done,
    input logic [DW-1:0] rsp_rdata
);

    p_beat_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata)
                                  && $stable(bus_be) && $stable(bus_burst) && $stable(bus_write));

    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !req_ready);

    p_done_follows_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(bus_valid && bus_ack));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_read_lanes_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_write |-> bus_wdata == 32'h0);

    p_write_enables_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write |-> bus_be != 4'b0000);

    p_burst_in_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_burst |-> bus_valid);

    p_result_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_write |-> rsp_rdata == '0);

endmodule

bind bus_width_adapter bwa_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .bus_valid (bus_valid),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .bus_write (bus_write),
    .bus_burst (bus_burst),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
);

// File: tb/sim_bus_width_adapter.sv
`timescale 1ns/1ps
module sim_bus_width_adapter;

    localparam int LW   = 4;
    localparam int DW   = 32 * LW;
    localparam int MAXB = 4 * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_port = 2'b00;
    logic          cfg_low_lanes = 1'b0, cfg_burst_wr = 1'b0, cfg_burst_rd = 1'b0, cfg_be_reads = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [31:0]   req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic          bus_valid, bus_write, bus_burst;
    logic          bus_ack = 1'b0;
    logic [31:0]   bus_addr, bus_wdata;
    logic [31:0]   bus_rdata = '0;
    logic [3:0]    bus_be;

    int n_tests = 0, n_fail = 0;
    int ack_mode = 0, ack_ctr = 0;
    bit started = 1'b0, m_hold = 1'b0, m_done = 1'b0;
    logic [DW-1:0] m_rdata = '0;
    string phase = "";

    // Expected beats
    logic [31:0]   q_addr[$];
    logic [3:0]    q_be[$];
    logic [31:0]   q_wd[$];
    bit            q_bst[$], q_last[$], q_wr[$], q_low[$];
    int            q_pb[$];
    logic [DW-1:0] q_rexp[$];

    always #4 clk = ~clk;   // 125 MHz

    bus_width_adapter #(.LINE_WORDS(LW), .AW(32)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_port(cfg_port), .cfg_low_lanes(cfg_low_lanes),
        .cfg_burst_wr(cfg_burst_wr), .cfg_burst_rd(cfg_burst_rd), .cfg_be_reads(cfg_be_reads),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_valid(bus_valid), .bus_ack(bus_ack), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_burst(bus_burst), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic int port_b(input logic [1:0] c);
        return (c == 2'b01) ? 1 : ((c == 2'b10) ? 2 : 4);
    endfunction

    function automatic int tot_b(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return MAXB;
        endcase
    endfunction

    // Bit position of stream byte k (R5 ordering)
    function automatic int byte_pos(input int t, input int k);
        return (t >= 4) ? (32*(k/4) + 8*(3 - k%4)) : (8*(t - 1 - k));
    endfunction

    // Behavioural memory contents seen by reads
    function automatic logic [7:0] mem_b(input logic [31:0] a);
        logic [31:0] h;
        h = a * 32'd29 + (a >> 3) + 32'h5A;
        return h[7:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s %s actual=%0h expected=%0h at %0t", req, phase, what, act, exp, $time);
        end
    endtask

    task automatic issue(input bit wr, input logic [1:0] sz, input logic [31:0] addr,
                         input logic [DW-1:0] wd);
        int p, t, b, n, top, ln, o0;
        logic [31:0] a, wdv;
        logic [3:0] be;
        logic [DW-1:0] rexp, tmp;
        bit bst;
        @(posedge clk); #1;
        while (!req_ready) begin @(posedge clk); #1; end
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
        p = port_b(cfg_port); t = tot_b(sz); b = (t < p) ? t : p; n = t / b;
        top = (cfg_low_lanes && p < 4) ? p - 1 : 3;
        bst = (wr ? cfg_burst_wr : cfg_burst_rd) && (n > 1);
        rexp = '0;
        for (int k = 0; k < t; k++) rexp = rexp | (DW'(mem_b(addr + 32'(k))) << byte_pos(t, k));
        for (int i = 0; i < n; i++) begin
            a = addr + 32'(i*b); o0 = int'(a % 32'(p)); be = '0; wdv = '0;
            for (int j = 0; j < b; j++) begin
                ln = top - o0 - j;
                if (wr || cfg_be_reads) be[ln] = 1'b1;
                if (wr) begin
                    tmp = wd >> byte_pos(t, i*b + j);
                    wdv[8*ln +: 8] = tmp[7:0];
                end
            end
            q_addr.push_back(a); q_be.push_back(be); q_wd.push_back(wdv);
            q_bst.push_back(bst && (i != n-1)); q_last.push_back(i == n-1);
            q_wr.push_back(wr); q_low.push_back(cfg_low_lanes); q_pb.push_back(p);
            q_rexp.push_back(rexp);
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain;
        while (q_addr.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    // Reference model: compared on every clock, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n && started) begin
            bit ack;
            int p, top;
            logic [31:0] rd, base;
            chk(rsp_done == m_done, "R9", "rsp_done", DW'(rsp_done), DW'(m_done));
            chk(rsp_rdata == m_rdata, "R8", "rsp_rdata", rsp_rdata, m_rdata);
            if (m_hold) chk(bus_valid == 1'b1, "R11", "beat dropped before ack", DW'(bus_valid), 1);
            rd = 32'hEEEE_EEEE;
            if (bus_valid) begin
                if (q_addr.size() == 0) begin
                    chk(1'b0, "R2", "unexpected beat", DW'(bus_addr), 0);
                end else begin
                    chk(bus_addr == q_addr[0], "R2", "bus_addr", DW'(bus_addr), DW'(q_addr[0]));
                    chk(bus_write == q_wr[0], "R2", "bus_write", DW'(bus_write), DW'(q_wr[0]));
                    chk(bus_be == q_be[0], (q_low[0] && q_pb[0] < 4) ? "R4/R7" : "R3/R7",
                        "bus_be", DW'(bus_be), DW'(q_be[0]));
                    chk(bus_wdata == q_wd[0], (q_low[0] && q_pb[0] < 4) ? "R4/R5" : "R3/R5",
                        "bus_wdata", DW'(bus_wdata), DW'(q_wd[0]));
                    chk(bus_burst == q_bst[0], "R6", "bus_burst", DW'(bus_burst), DW'(q_bst[0]));
                    p = q_pb[0];
                    top = (q_low[0] && p < 4) ? p - 1 : 3;
                    base = q_addr[0] - (q_addr[0] % 32'(p));
                    for (int o = 0; o < p; o++) rd[8*(top-o) +: 8] = mem_b(base + 32'(o));
                end
            end
            ack = (ack_mode == 0) ? 1'b1 : ((ack_ctr % 3) != 0);
            ack_ctr++;
            bus_ack   = ack;
            bus_rdata = rd;
            // Effects of the coming edge
            m_done = 1'b0;
            m_hold = bus_valid && !ack;
            if (req_valid && req_ready) m_rdata = '0;
            if (bus_valid && ack && q_addr.size() != 0) begin
                if (q_last[0]) begin
                    m_done = 1'b1;
                    if (!q_wr[0]) m_rdata = q_rexp[0];
                end
                void'(q_addr.pop_front()); void'(q_be.pop_front()); void'(q_wd.pop_front());
                void'(q_bst.pop_front()); void'(q_last.pop_front()); void'(q_wr.pop_front());
                void'(q_low.pop_front()); void'(q_pb.pop_front()); void'(q_rexp.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, transfer never completed");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        phase = "reset";
        chk(req_ready == 1'b1, "R1", "req_ready", DW'(req_ready), 1);
        chk(bus_valid == 1'b0, "R1", "bus_valid", DW'(bus_valid), 0);
        chk(rsp_done == 1'b0, "R1", "rsp_done", DW'(rsp_done), 0);
        chk(rsp_rdata == '0, "R1", "rsp_rdata", rsp_rdata, 0);
        started = 1'b1;

        // 32-bit port: word and sub-word placement (R3, R5)
        phase = "p32";
        issue(1, 2'd2, 32'h100, DW'(32'h1122_3344));
        for (int o = 0; o < 4; o++) issue(1, 2'd0, 32'h200 + 32'(o), DW'(8'hA0 + 8'(o)));
        issue(1, 2'd1, 32'h302, DW'(16'hBEEF));
        cfg_be_reads = 1'b1;
        issue(0, 2'd1, 32'h402, '0);
        issue(0, 2'd0, 32'h403, '0);
        drain();

        // 8-bit port, upper lanes, split then burst writes (R2, R6)
        phase = "p8";
        cfg_port = 2'b01; cfg_be_reads = 1'b0; ack_mode = 1;
        issue(1, 2'd2, 32'h500, DW'(32'hCAFE_F00D));
        cfg_burst_wr = 1'b1;
        issue(1, 2'd2, 32'h504, DW'(32'h0102_0304));
        issue(0, 2'd2, 32'h508, '0);
        drain();

        // 8-bit port, lower lanes, burst reads (R4, R8)
        phase = "p8low";
        cfg_low_lanes = 1'b1; cfg_burst_rd = 1'b1;
        issue(0, 2'd2, 32'h600, '0);
        cfg_burst_rd = 1'b0;
        issue(0, 2'd1, 32'h610, '0);
        issue(1, 2'd1, 32'h612, DW'(16'h5AA5));
        drain();

        // 16-bit port both placements, line read in burst (R2, R4, R6)
        phase = "p16";
        cfg_port = 2'b10; cfg_low_lanes = 1'b0; cfg_be_reads = 1'b1;
        issue(1, 2'd1, 32'h700, DW'(16'h1234));
        issue(0, 2'd0, 32'h701, '0);
        cfg_low_lanes = 1'b1; cfg_burst_rd = 1'b1;
        issue(0, 2'd3, 32'h740, '0);
        issue(1, 2'd0, 32'h745, DW'(8'h77));
        drain();

        // 32-bit port (code 11) line writes, burst and split (R3, R5, R6)
        phase = "line32";
        cfg_port = 2'b11; cfg_low_lanes = 1'b0; ack_mode = 0;
        issue(1, 2'd3, 32'h800, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF);
        cfg_burst_wr = 1'b0;
        issue(1, 2'd3, 32'h810, 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F);
        issue(0, 2'd3, 32'h820, '0);
        drain();

        // R10: configuration changed while a transfer is in flight
        phase = "R10";
        cfg_port = 2'b01; cfg_low_lanes = 1'b0; cfg_burst_wr = 1'b1; ack_mode = 1;
        issue(1, 2'd2, 32'h900, DW'(32'h9876_5432));
        cfg_port = 2'b00; cfg_low_lanes = 1'b1; cfg_burst_wr = 1'b0; cfg_be_reads = 1'b0;
        drain();
        cfg_port = 2'b10; cfg_low_lanes = 1'b0; cfg_burst_rd = 1'b1; cfg_be_reads = 1'b1;
        issue(0, 2'd2, 32'h910, '0);
        cfg_port = 2'b01; cfg_burst_rd = 1'b0; cfg_be_reads = 1'b0;
        drain();

        // Completion and next acceptance in the same cycle (R8, R9)
        phase = "b2b";
        cfg_port = 2'b01; cfg_burst_rd = 1'b1; ack_mode = 0;
        issue(0, 2'd1, 32'hA00, '0);
        issue(1, 2'd2, 32'hA10, DW'(32'h2468_ACE0));
        issue(0, 2'd2, 32'hA20, '0);
        cfg_port = 2'b00;
        issue(0, 2'd0, 32'hA31, '0);
        drain();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule